// File: doc/BRIEF.md
# Fractional clock divider with triggered commit

This block turns a fast input clock into a train of one-cycle clock-enable pulses whose average spacing equals a programmable divisor. The divisor may have a fractional part. Software places the divisor in a field of a 32-bit divider word. The field holds the divisor minus one. Its lowest `FRAC_W` bits are the fractional part, and the offset of one applies only to the integer bits above them. In scaled terms, the divisor times 2^FRAC_W equals the field value plus 2^FRAC_W. An accumulator adds the fractional part once per output period and stretches a period by one input cycle each time it carries.

A written divisor is only staged. It takes effect when software writes 1 to a trigger bit in a second word. That bit reads back 1 until the divider has switched and 0 afterwards, so software can poll it. The switch happens only at an output period boundary. A trigger written while the clock gate is off stays pending, and it completes once the gate is back on and the running period ends.

With the gate off the pulse train stops and the divider state freezes. Downstream logic uses `div_en` as a clock enable in the input clock domain.

Top module: `frac_clk_div`

## Requirements
- R1: The divisor field occupies bits [SHIFT+FIELD_W-1:SHIFT] (default [11:4]) of the word at address 0. Reading address 0 returns the staged field in that position and 0 in every other bit.
- R2: With the fraction bits of the field at zero, every output period lasts exactly (field >> FRAC_W) + 1 gated input cycles (default FRAC_W = 2, so field 12 gives periods of 4 cycles).
- R3: Let S = field + 2^FRAC_W be the scaled divisor. The k-th pulse after a commit comes floor(k*S / 2^FRAC_W) gated cycles after the commit pulse. Each period therefore lasts either the integer part plus one or the integer part plus two.
- R4: Writing the divider word changes only the staged value. It leaves the pulse spacing unchanged until a trigger is committed.
- R5: Writing address 1 with bit TRIG_BIT (default 0) set to 1 makes that bit read 1 from the next cycle on. It reads 0 once the new divisor is in use.
- R6: The output period that is running when a trigger arrives completes with the old length. The new divisor governs the periods that start at that pulse, and the fractional accumulator restarts from zero at that moment.
- R7: While `gate_on` is low, no pulse is produced and the progress of the running period is frozen. A pending trigger stays busy and commits at the first period end after the gate returns high.
- R8: A write to address 1 with bit TRIG_BIT at 0 has no effect: the trigger stays idle and the pulse spacing is unchanged.
- R9: After reset, the staged and active fields equal RESET_FIELD (default 0, divide by one) and the trigger reads 0. With the default, the first gated cycle already pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_on | input | 1 | Clock gate state; high lets the divider run |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Combinational readback of the addressed word |
| div_en | output | 1 | One-cycle enable pulse at the end of every output period |

## Verification
The assertions take several things for granted about the inputs. They assume that `gate_on`, the write strobe, the address and the data are synchronous to `clk` and hold steady around each rising edge. They assume that reset is held for at least one edge. They also assume that the field parameters fit inside the 32-bit word. The stimulus changes every input two nanoseconds after a rising edge, samples outputs at the falling edge and uses only the two defined addresses. It raises and lowers the gate only between edges, so every period length the scoreboard measures counts whole gated cycles.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Decoded target of a register access.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_TRIG = 2'd2
  } fdiv_sel_e;

  // The divisor field must lie inside one 32-bit word.
  function automatic bit field_fits(input int unsigned shift, input int unsigned width);
    return (shift + width) <= 32;
  endfunction

  // The trigger bit must lie inside one 32-bit word.
  function automatic bit bit_fits(input int unsigned pos);
    return pos < 32;
  endfunction

endpackage

// File: rtl/fdiv_phase.sv
// Fractional phase step: adds the fractional part to the accumulator and
// reports a carry that lengthens the coming period by one input cycle.
module fdiv_phase #(
  parameter int unsigned FRAC_W = 2
) (
  input  logic [FRAC_W-1:0] acc_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              restart_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic              carry_o
);

  logic [FRAC_W-1:0] base;
  logic [FRAC_W:0]   sum;

  always_comb begin
    base    = restart_i ? '0 : acc_i;
    sum     = {1'b0, base} + {1'b0, frac_i};
    acc_o   = sum[FRAC_W-1:0];
    carry_o = sum[FRAC_W];
  end

endmodule

// File: rtl/fdiv_regs.sv
// Register file: staged divisor word, trigger/busy handshake, readback.
module fdiv_regs #(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SHIFT       = 4,
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned TRIG_BIT    = 0,
  parameter int unsigned DIV_ADDR    = 0,
  parameter int unsigned TRIG_ADDR   = 1,
  parameter int unsigned RESET_FIELD = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic               commit_i,
  output logic [FIELD_W-1:0] staged_o,
  output logic               busy_o,
  output logic [31:0]        rd_data_o
);
  import fdiv_pkg::*;

  localparam logic [FIELD_W-1:0] RST_FIELD = FIELD_W'(RESET_FIELD);

  initial begin
    assert (field_fits(SHIFT, FIELD_W) && bit_fits(TRIG_BIT))
      else $error("fdiv_regs: field or trigger bit outside the 32-bit word");
  end

  function automatic fdiv_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(DIV_ADDR))  return SEL_DIV;
    if (a == ADDR_W'(TRIG_ADDR)) return SEL_TRIG;
    return SEL_NONE;
  endfunction

  fdiv_sel_e          wr_sel, rd_sel;
  logic               div_wr, trig_wr, trig_arm;
  logic [FIELD_W-1:0] staged_q;
  logic               busy_q;
  logic               unused_wdata;

  assign wr_sel       = decode(wr_addr_i);
  assign rd_sel       = decode(rd_addr_i);
  assign div_wr       = wr_en_i && (wr_sel == SEL_DIV);
  assign trig_wr      = wr_en_i && (wr_sel == SEL_TRIG);
  assign trig_arm     = trig_wr && wr_data_i[TRIG_BIT] && !busy_q;
  assign unused_wdata = ^wr_data_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      staged_q <= RST_FIELD;
      busy_q   <= 1'b0;
    end else begin
      if (div_wr) staged_q <= wr_data_i[SHIFT +: FIELD_W];
      if (commit_i)      busy_q <= 1'b0;
      else if (trig_arm) busy_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_sel)
      SEL_DIV:  rd_data_o[SHIFT +: FIELD_W] = staged_q;
      SEL_TRIG: rd_data_o[TRIG_BIT]         = busy_q;
      default:  ;
    endcase
  end

  assign staged_o = staged_q;
  assign busy_o   = busy_q;

  // R5: an accepted trigger is visible as busy on the next cycle.
  a_r5_trig_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr && wr_data_i[TRIG_BIT] && !busy_q) |=> busy_q);

  // R6: busy only clears at a commit signalled by the divide engine.
  a_r6_busy_drop_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(commit_i));

  // R8: a trigger-word write with the trigger bit low leaves the handshake idle.
  a_r8_zero_trig_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr && !wr_data_i[TRIG_BIT] && !busy_q) |=> !busy_q);

endmodule

// File: rtl/fdiv_engine.sv
// Divide engine: period counter, active divisor and fractional phase.
module fdiv_engine #(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned FRAC_W      = 2,
  parameter int unsigned RESET_FIELD = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_on_i,
  input  logic               busy_i,
  input  logic [FIELD_W-1:0] staged_i,
  output logic               pulse_o,
  output logic               commit_o
);

  localparam int unsigned INT_W = FIELD_W - FRAC_W;
  localparam int unsigned CNT_W = INT_W + 1;
  localparam logic [FIELD_W-1:0] RST_FIELD = FIELD_W'(RESET_FIELD);

  function automatic logic [INT_W-1:0] int_of(input logic [FIELD_W-1:0] f);
    return f[FIELD_W-1:FRAC_W];
  endfunction

  function automatic logic [FRAC_W-1:0] frac_of(input logic [FIELD_W-1:0] f);
    return f[FRAC_W-1:0];
  endfunction

  // Cycles remaining after the pulse: integer part plus a carry stretch.
  function automatic logic [CNT_W-1:0] count_for(input logic [FIELD_W-1:0] f,
                                                 input logic c);
    return {1'b0, int_of(f)} + CNT_W'(c);
  endfunction

  localparam logic [CNT_W-1:0]  RST_CNT = count_for(RST_FIELD, 1'b0);
  localparam logic [FRAC_W-1:0] RST_ACC = frac_of(RST_FIELD);

  logic [FIELD_W-1:0] active_q, next_field;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAC_W-1:0]  acc_q, acc_nxt;
  logic               carry;
  logic               period_end, commit;

  assign period_end = gate_on_i && (cnt_q == '0);
  assign commit     = period_end && busy_i;
  assign next_field = commit ? staged_i : active_q;

  fdiv_phase #(.FRAC_W(FRAC_W)) u_phase (
    .acc_i     (acc_q),
    .frac_i    (frac_of(next_field)),
    .restart_i (commit),
    .acc_o     (acc_nxt),
    .carry_o   (carry)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_q <= RST_FIELD;
      cnt_q    <= RST_CNT;
      acc_q    <= RST_ACC;
    end else if (period_end) begin
      active_q <= next_field;
      acc_q    <= acc_nxt;
      cnt_q    <= count_for(next_field, carry);
    end else if (gate_on_i) begin
      cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  assign pulse_o  = period_end;
  assign commit_o = commit;

  // Independent period measurement used by the assertions below.
  logic [CNT_W:0]   gap_q;
  logic [INT_W-1:0] len_int_q;
  logic [CNT_W:0]   len_now;

  assign len_now = gap_q + (CNT_W+1)'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      len_int_q <= int_of(RST_FIELD);
    end else if (period_end) begin
      gap_q     <= '0;
      len_int_q <= int_of(next_field);
    end else if (gate_on_i) begin
      gap_q     <= gap_q + (CNT_W+1)'(1);
    end
  end

  // R3: each period is the integer part plus one, or plus two on a carry.
  a_r3_period_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |-> ((len_now == {2'b00, len_int_q} + (CNT_W+1)'(1)) ||
                    (len_now == {2'b00, len_int_q} + (CNT_W+1)'(2))));

  // R6: the divisor in use changes only at a commit.
  a_r6_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(active_q));

  // R7: with the gate low, period progress and phase are frozen.
  a_r7_frozen_when_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_on_i |=> ($stable(cnt_q) && $stable(acc_q)));

endmodule

// File: rtl/frac_clk_div.sv
// Top: fractional clock divider with staged divisor and triggered commit.
module frac_clk_div #(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SHIFT       = 4,
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned FRAC_W      = 2,
  parameter int unsigned TRIG_BIT    = 0,
  parameter int unsigned DIV_ADDR    = 0,
  parameter int unsigned TRIG_ADDR   = 1,
  parameter int unsigned RESET_FIELD = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_on,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              div_en
);

  logic [FIELD_W-1:0] staged;
  logic               busy;
  logic               commit;

  fdiv_regs #(
    .ADDR_W      (ADDR_W),
    .SHIFT       (SHIFT),
    .FIELD_W     (FIELD_W),
    .TRIG_BIT    (TRIG_BIT),
    .DIV_ADDR    (DIV_ADDR),
    .TRIG_ADDR   (TRIG_ADDR),
    .RESET_FIELD (RESET_FIELD)
  ) u_regs (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .commit_i  (commit),
    .staged_o  (staged),
    .busy_o    (busy),
    .rd_data_o (rd_data)
  );

  fdiv_engine #(
    .FIELD_W     (FIELD_W),
    .FRAC_W      (FRAC_W),
    .RESET_FIELD (RESET_FIELD)
  ) u_engine (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .gate_on_i (gate_on),
    .busy_i    (busy),
    .staged_i  (staged),
    .pulse_o   (div_en),
    .commit_o  (commit)
  );

endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;

  localparam int SHIFT = 4;
  localparam int Q     = 4;   // 2**FRAC_W

  logic        clk = 1'b0;
  logic        rst_n, gate_on, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        div_en;

  int total = 0;
  int bad   = 0;
  bit mon_on = 0;
  int gap = 0;
  int    exp_len[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  frac_clk_div u_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .div_en(div_en)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Expected length of the k-th period after a commit (R3 formulation).
  function automatic int exp_period(input int field, input int k);
    longint s = longint'(field) + Q;
    return int'((longint'(k) * s) / Q - (longint'(k - 1) * s) / Q);
  endfunction

  // Monitor: measures gated cycles between pulses and pops the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      if (gate_on) gap++;
      if (div_en) begin
        if (exp_len.size() > 0) begin
          int    l;
          string t;
          l = exp_len.pop_front();
          t = exp_tag.pop_front();
          chk(gap == l, t, gap, l);
        end
        gap = 0;
      end
    end
  end

  task automatic push(input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic push_field(input int field, input int n, input string tag);
    for (int k = 1; k <= n; k++) push(exp_period(field, k), tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic sync_pulse();
    do @(negedge clk); while (!div_en);
    @(posedge clk); #2;
  endtask

  task automatic drain();
    wait (exp_len.size() == 0);
    @(posedge clk); #2;
  endtask

  // Stage a field, trigger it, and score the periods that follow the commit.
  task automatic commit_to(input int field, input int n, input string tag);
    drain();
    wr(2'd0, 32'(field) << SHIFT);
    rd_chk(2'd0, 32'(field) << SHIFT, "R1");
    wr(2'd1, 32'd1);
    rd_chk(2'd1, 32'd1, "R5");
    sync_pulse();
    push_field(field, n, tag);
    rd_chk(2'd1, 32'd0, "R5");
    drain();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    int npulse;
    rst_n = 1'b0; gate_on = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R9: reset state
    rd_chk(2'd0, 32'd0, "R9");
    rd_chk(2'd1, 32'd0, "R9");
    chk(div_en == 1'b0, "R9", div_en, 0);
    mon_on = 1;

    // R9: divide by one from the first gated cycle
    for (int i = 0; i < 4; i++) push(1, "R9");
    gate_on = 1'b1;
    drain();

    // R4 and R1: a staged write alone changes nothing at the output
    sync_pulse();
    for (int i = 0; i < 4; i++) push(1, "R4");
    wr(2'd0, 32'hFFFF_FFFF);
    drain();
    rd_chk(2'd0, 32'h0000_0FF0, "R1");

    // R2: integer divisors
    commit_to(12, 4, "R2");
    commit_to(28, 3, "R2");

    // R3: fractional divisors 2.5, 4.25 and 1.75
    commit_to(6, 8, "R3");
    commit_to(13, 8, "R3");
    commit_to(3, 8, "R3");

    // R6: trigger mid-period; old period completes, then new divisor (3)
    commit_to(28, 2, "R2");
    sync_pulse();
    push(8, "R6");
    push_field(8, 3, "R6");
    wr(2'd0, 32'd8 << SHIFT);
    wr(2'd1, 32'd1);
    rd_chk(2'd1, 32'd1, "R6");
    drain();
    rd_chk(2'd1, 32'd0, "R6");

    // R7: gate off freezes everything and holds the pending trigger
    sync_pulse();
    gate_on = 1'b0;
    push(3, "R7");
    push_field(12, 3, "R7");
    wr(2'd0, 32'd12 << SHIFT);
    wr(2'd1, 32'd1);
    npulse = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (div_en) npulse++;
    end
    @(posedge clk); #2;
    chk(npulse == 0, "R7", npulse, 0);
    rd_chk(2'd1, 32'd1, "R7");
    gate_on = 1'b1;
    drain();
    rd_chk(2'd1, 32'd0, "R7");

    // R8: trigger word written with the trigger bit clear
    wr(2'd0, 32'd6 << SHIFT);
    wr(2'd1, 32'hFFFF_FFFE);
    rd_chk(2'd1, 32'd0, "R8");
    sync_pulse();
    for (int i = 0; i < 3; i++) push(4, "R8");
    drain();

    report();
    $finish;
  end

endmodule